// File: doc/BRIEF.md
# SECDED Memory Word Protection Wrapper

This block guards the words that travel to and from a memory with an extended Hamming code. It corrects any single flipped bit and flags any two flipped bits. On the store side, each 64-bit data lane is extended with seven check bits and one overall parity bit, which gives a 72-bit codeword. On the load side, each 72-bit codeword is checked. The block returns the repaired 64-bit data, one flag for a corrected single-bit error and one flag for a detected double-bit error. A wide word is handled as several independent lanes placed side by side.

A build-time mode picks which halves are present, and the port widths follow that choice:

- **Full mode:** both the encoder and the decoder are present.
- **Encoder-only mode:** the load side returns the raw 72-bit codewords unchanged.
- **Decoder-only mode:** the store side takes ready-made 72-bit codewords and forwards them untouched.

Two test inputs corrupt an outgoing codeword on purpose, so that the error handling of the surrounding system can be exercised. Each side has one register stage. The error flags pass through the same register as the data they describe.

Top module: `ecc_secded_wrap`

## Requirements
- R1: Codeword layout for each lane:
  - Bits 63:0 hold the data.
  - Bit 64+j holds check bit j. Check bit j is the XOR of the data bits whose Hamming position has bit j set. Data bits take the non-power-of-two positions 3, 5, 6, 7, 9, and so on, in ascending order.
  - Bit 71 makes the XOR of all 72 bits zero.
- R2: `wr_code_o` and `wr_vld_o` reflect a store strobe at the first rising clock edge after `wr_vld_i` is sampled high. `wr_vld_o` is low after an edge where `wr_vld_i` was low. `wr_code_o` holds its value while no store is strobed.
- R3: A codeword without errors decodes to its original data, with both flags low.
- R4: A codeword with any one of its 72 bits flipped decodes to the original data. The single-error flag is high and the double-error flag is low.
- R5: A codeword with two bits flipped raises the double-error flag and leaves the single-error flag low. The data bits 63:0 are then passed through without correction.
- R6: `rd_data_o`, the flags and `rd_vld_o` update at the first rising edge after `rd_vld_i` is high. While `rd_vld_i` is low, the data and flags hold.
- R7: A single-error request flips codeword bit 0 of every lane. A double-error request flips bits 0 and 1. When both requests are raised, the double-error request wins.
- R8: In encoder-only mode, `rd_data_o` is the 72-bit codeword as received, and both flags stay low.
- R9: In decoder-only mode, `wr_code_o` equals the 72-bit `wr_data_i` as received, and the error-injection inputs have no effect.
- R10: While `rst_ni` is low, every output register is zero.
- R11: Each lane has its own code and its own flags. An error in one lane does not disturb the data or flags of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_vld_i | input | 1 | Store strobe |
| wr_data_i | input | LANES*64, or LANES*72 in decoder-only mode | Store data, or codewords in decoder-only mode |
| inj_sbit_i | input | 1 | Request a single-bit corruption of the stored codeword |
| inj_dbit_i | input | 1 | Request a double-bit corruption of the stored codeword |
| wr_vld_o | output | 1 | Registered store strobe |
| wr_code_o | output | LANES*72 | Codewords toward the memory |
| rd_vld_i | input | 1 | Load strobe |
| rd_code_i | input | LANES*72 | Codewords from the memory |
| rd_vld_o | output | 1 | Registered load strobe |
| rd_data_o | output | LANES*64, or LANES*72 in encoder-only mode | Corrected data, or raw codewords in encoder-only mode |
| sbit_err_o | output | LANES | Per lane: single-bit error corrected |
| dbit_err_o | output | LANES | Per lane: double-bit error detected |

## Verification
Every result in this block lands exactly one rising edge after its strobe:

- On the store side, the codeword follows `wr_vld_i` by one edge.
- On the load side, the corrected data and both flags follow `rd_vld_i` by one edge.

The bench drives each strobe on a falling edge and drops it at the next falling edge. It compares outputs only at that next falling edge, half a period after the capturing edge. Latency checks also look just after the strobe is raised and before the edge, to confirm that nothing has moved yet. Hold checks change `rd_code_i` with the strobe low and compare again one full cycle later.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 7;
    localparam int CODE_W = 72;

    typedef enum logic [1:0] {
        ECC_BOTH     = 2'd0,
        ECC_ENC_ONLY = 2'd1,
        ECC_DEC_ONLY = 2'd2
    } ecc_mode_e;

    // Hamming position of data bit idx: the idx-th non-power-of-two position.
    function automatic int data_pos(int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 3; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Data bits that feed check bit j.
    function automatic logic [DATA_W-1:0] chk_mask(int j);
        logic [DATA_W-1:0] m;
        int pos;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pos  = data_pos(i);
            m[i] = pos[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_enc_lane.sv
module ecc_enc_lane
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic              inj_s_i,
    input  logic              inj_d_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CHK_W-1:0]  chk;
    logic [CODE_W-1:0] clean;
    logic [CODE_W-1:0] flip;

    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        localparam logic [DATA_W-1:0] MASK = chk_mask(j);
        assign chk[j] = ^(data_i & MASK);
    end

    assign clean = {^{chk, data_i}, chk, data_i};

    // Injection acts on the finished codeword; double request wins.
    always_comb begin
        flip = '0;
        if (inj_d_i)      flip[1:0] = 2'b11;
        else if (inj_s_i) flip[0]   = 1'b1;
    end

    assign code_o = clean ^ flip;

endmodule

// File: rtl/ecc_dec_lane.sv
module ecc_dec_lane
    import ecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sbit_o,
    output logic              dbit_o
);

    logic [DATA_W-1:0] raw;
    logic [CHK_W-1:0]  recomp;
    logic [CHK_W-1:0]  syn;
    logic              par_odd;
    logic [DATA_W-1:0] fix;

    assign raw = code_i[DATA_W-1:0];

    for (genvar j = 0; j < CHK_W; j++) begin : g_syn
        localparam logic [DATA_W-1:0] MASK = chk_mask(j);
        assign recomp[j] = ^(raw & MASK);
    end

    assign syn     = recomp ^ code_i[DATA_W +: CHK_W];
    assign par_odd = ^code_i;

    // A data bit is repaired only for an odd error count whose syndrome names it.
    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam int POS = data_pos(i);
        assign fix[i] = par_odd && (syn == CHK_W'(POS));
    end

    assign data_o = raw ^ fix;
    assign sbit_o = par_odd;
    assign dbit_o = !par_odd && (syn != '0);

endmodule

// File: rtl/ecc_secded_wrap.sv
module ecc_secded_wrap
    import ecc_pkg::*;
#(
    parameter int        LANES = 2,
    parameter ecc_mode_e MODE  = ECC_BOTH
) (
    input  logic                                                        clk_i,
    input  logic                                                        rst_ni,
    input  logic                                                        wr_vld_i,
    input  logic [((MODE == ECC_DEC_ONLY) ? CODE_W : DATA_W)*LANES-1:0] wr_data_i,
    input  logic                                                        inj_sbit_i,
    input  logic                                                        inj_dbit_i,
    output logic                                                        wr_vld_o,
    output logic [CODE_W*LANES-1:0]                                     wr_code_o,
    input  logic                                                        rd_vld_i,
    input  logic [CODE_W*LANES-1:0]                                     rd_code_i,
    output logic                                                        rd_vld_o,
    output logic [((MODE == ECC_ENC_ONLY) ? CODE_W : DATA_W)*LANES-1:0] rd_data_o,
    output logic [LANES-1:0]                                            sbit_err_o,
    output logic [LANES-1:0]                                            dbit_err_o
);

    localparam int CW_W     = CODE_W * LANES;
    localparam int RD_OUT_W = ((MODE == ECC_ENC_ONLY) ? CODE_W : DATA_W) * LANES;

    typedef struct packed {
        logic                wr_vld;
        logic [CW_W-1:0]     wr_code;
        logic                rd_vld;
        logic [RD_OUT_W-1:0] rd_data;
        logic [LANES-1:0]    sbit;
        logic [LANES-1:0]    dbit;
    } state_t;

    state_t              st_d, st_q;
    logic [CW_W-1:0]     enc_code;
    logic [RD_OUT_W-1:0] dec_data;
    logic [LANES-1:0]    dec_sbit;
    logic [LANES-1:0]    dec_dbit;

    // Store side
    if (MODE == ECC_DEC_ONLY) begin : g_wr_pass
        logic unused_inj;
        assign unused_inj = inj_sbit_i ^ inj_dbit_i;
        assign enc_code   = wr_data_i;
    end else begin : g_wr_enc
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            ecc_enc_lane u_enc (
                .data_i  (wr_data_i[l*DATA_W +: DATA_W]),
                .inj_s_i (inj_sbit_i),
                .inj_d_i (inj_dbit_i),
                .code_o  (enc_code[l*CODE_W +: CODE_W])
            );
        end
    end

    // Load side
    if (MODE == ECC_ENC_ONLY) begin : g_rd_pass
        assign dec_data = rd_code_i;
        assign dec_sbit = '0;
        assign dec_dbit = '0;
    end else begin : g_rd_dec
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            ecc_dec_lane u_dec (
                .code_i (rd_code_i[l*CODE_W +: CODE_W]),
                .data_o (dec_data[l*DATA_W +: DATA_W]),
                .sbit_o (dec_sbit[l]),
                .dbit_o (dec_dbit[l])
            );
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.wr_vld = wr_vld_i;
        st_d.rd_vld = rd_vld_i;
        if (wr_vld_i) st_d.wr_code = enc_code;
        if (rd_vld_i) begin
            st_d.rd_data = dec_data;
            st_d.sbit    = dec_sbit;
            st_d.dbit    = dec_dbit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign wr_vld_o   = st_q.wr_vld;
    assign wr_code_o  = st_q.wr_code;
    assign rd_vld_o   = st_q.rd_vld;
    assign rd_data_o  = st_q.rd_data;
    assign sbit_err_o = st_q.sbit;
    assign dbit_err_o = st_q.dbit;

    // Checks
    p_wr_vld_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_vld_i |=> wr_vld_o);
    p_wr_vld_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_vld_i |=> !wr_vld_o && $stable(wr_code_o));
    p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_vld_i |=> !rd_vld_o && $stable(rd_data_o) && $stable(sbit_err_o)
                      && $stable(dbit_err_o));

    if (MODE != ECC_DEC_ONLY) begin : g_enc_chk
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            p_clean_parity_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_vld_i && !inj_sbit_i && !inj_dbit_i
                |=> (^wr_code_o[l*CODE_W +: CODE_W]) == 1'b0);
            p_inj_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_vld_i && inj_sbit_i && !inj_dbit_i
                |=> (^wr_code_o[l*CODE_W +: CODE_W]) == 1'b1);
        end
    end else begin : g_pass_chk
        p_wr_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wr_vld_i |=> wr_code_o == $past(wr_data_i));
    end

    if (MODE == ECC_ENC_ONLY) begin : g_noflag_chk
        p_no_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sbit_err_o == '0 && dbit_err_o == '0);
    end else begin : g_flag_chk
        p_flag_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sbit_err_o & dbit_err_o) == '0);
    end

endmodule

// File: tb/test_ecc_secded_wrap.sv
`timescale 1ns/1ps
module test_ecc_secded_wrap;
    import ecc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // Shared controls
    logic wr_vld = 0, rd_vld = 0, inj_s = 0, inj_d = 0;

    // Full mode, two lanes
    logic [127:0] wr_data = '0;
    logic         wr_vld_o;
    logic [143:0] wr_code;
    logic [143:0] rd_code = '0;
    logic         rd_vld_o;
    logic [127:0] rd_data;
    logic [1:0]   sbe, dbe;

    // Encoder-only, one lane
    logic [63:0] e_wr_data = '0;
    logic        e_wv, e_rv;
    logic [71:0] e_wr_code, e_rd_code = '0, e_rd_data;
    logic [0:0]  e_sbe, e_dbe;

    // Decoder-only, one lane
    logic [71:0] d_wr_data = '0, d_wr_code, d_rd_code = '0;
    logic        d_wv, d_rv;
    logic [63:0] d_rd_data;
    logic [0:0]  d_sbe, d_dbe;

    ecc_secded_wrap #(.LANES(2), .MODE(ECC_BOTH)) i_ecc_secded_wrap (
        .clk_i(clk), .rst_ni(rst_n), .wr_vld_i(wr_vld), .wr_data_i(wr_data),
        .inj_sbit_i(inj_s), .inj_dbit_i(inj_d), .wr_vld_o(wr_vld_o), .wr_code_o(wr_code),
        .rd_vld_i(rd_vld), .rd_code_i(rd_code), .rd_vld_o(rd_vld_o), .rd_data_o(rd_data),
        .sbit_err_o(sbe), .dbit_err_o(dbe));

    ecc_secded_wrap #(.LANES(1), .MODE(ECC_ENC_ONLY)) i_ecc_secded_wrap_eo (
        .clk_i(clk), .rst_ni(rst_n), .wr_vld_i(wr_vld), .wr_data_i(e_wr_data),
        .inj_sbit_i(inj_s), .inj_dbit_i(inj_d), .wr_vld_o(e_wv), .wr_code_o(e_wr_code),
        .rd_vld_i(rd_vld), .rd_code_i(e_rd_code), .rd_vld_o(e_rv), .rd_data_o(e_rd_data),
        .sbit_err_o(e_sbe), .dbit_err_o(e_dbe));

    ecc_secded_wrap #(.LANES(1), .MODE(ECC_DEC_ONLY)) i_ecc_secded_wrap_do (
        .clk_i(clk), .rst_ni(rst_n), .wr_vld_i(wr_vld), .wr_data_i(d_wr_data),
        .inj_sbit_i(inj_s), .inj_dbit_i(inj_d), .wr_vld_o(d_wv), .wr_code_o(d_wr_code),
        .rd_vld_i(rd_vld), .rd_code_i(d_rd_code), .rd_vld_o(d_rv), .rd_data_o(d_rd_data),
        .sbit_err_o(d_sbe), .dbit_err_o(d_dbe));

    localparam logic [63:0] VEC [8] = '{
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
        64'hA5A5_5A5A_0F0F_F0F0, 64'h0123_4567_89AB_CDEF,
        64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_3333_CCCC};

    // Independent model: walk Hamming positions 1..71, skipping powers of two.
    function automatic logic [71:0] ref_enc(input logic [63:0] d);
        logic [6:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int j = 0; j < 7; j++) if (p[j]) c[j] = c[j] ^ d[k];
                k++;
            end
        end
        return {^{c, d}, c, d};
    endfunction

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [127:0] d, input logic s, input logic dd);
        @(negedge clk);
        wr_vld = 1; wr_data = d; inj_s = s; inj_d = dd;
        @(negedge clk);
        wr_vld = 0; inj_s = 0; inj_d = 0;
    endtask

    task automatic do_read(input logic [143:0] c);
        @(negedge clk);
        rd_vld = 1; rd_code = c;
        @(negedge clk);
        rd_vld = 0;
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0]  v0, v1;
        logic [71:0]  c0, c1;
        repeat (3) @(negedge clk);
        // R10: outputs zero while reset low
        chk("R10 reset main", {wr_vld_o, wr_code, rd_vld_o, rd_data, sbe, dbe}, '0);
        chk("R10 reset modes", {e_wv, e_wr_code, e_rd_data, d_wv, d_wr_code, d_rd_data}, '0);
        rst_n = 1;

        // R2 / R6: latency of one edge
        @(negedge clk);
        wr_vld = 1; wr_data = {VEC[5], VEC[4]}; rd_vld = 1; rd_code = {ref_enc(VEC[6]), ref_enc(VEC[7])};
        #1;
        chk("R2 not yet", {wr_vld_o, wr_code}, '0);
        chk("R6 not yet", {rd_vld_o, rd_data}, '0);
        @(negedge clk);
        chk("R2 after edge", {wr_vld_o, wr_code}, {1'b1, ref_enc(VEC[5]), ref_enc(VEC[4])});
        chk("R6 after edge", {rd_vld_o, rd_data, sbe, dbe}, {1'b1, VEC[6], VEC[7], 4'b0});
        wr_vld = 0; rd_vld = 0;
        @(negedge clk);
        chk("R2 strobe drops", {wr_vld_o, rd_vld_o}, 2'b00);

        // R1 R3 R11: table of round trips, lanes carry different data
        for (int i = 0; i < 8; i++) begin
            v0 = VEC[i];
            v1 = ~VEC[(i + 3) % 8];
            do_write({v1, v0}, 0, 0);
            chk("R1 R11 encode", wr_code, {ref_enc(v1), ref_enc(v0)});
            do_read(wr_code);
            chk("R3 clean decode", {rd_data, sbe, dbe}, {v1, v0, 4'b0000});
        end

        // R4 R11: every single flip position in lane 0, lane 1 clean
        v0 = VEC[6]; v1 = VEC[5];
        for (int b = 0; b < 72; b++) begin
            c0 = ref_enc(v0) ^ (72'd1 << b);
            do_read({ref_enc(v1), c0});
            chk($sformatf("R4 flip bit %0d", b), {rd_data, sbe, dbe}, {v1, v0, 2'b01, 2'b00});
        end

        // R5 R11: double flips in lane 1, data passed raw
        begin
            int pa [5] = '{0, 5, 63, 64, 10};
            int pb [5] = '{1, 70, 71, 65, 40};
            for (int k = 0; k < 5; k++) begin
                c1 = ref_enc(v1) ^ (72'd1 << pa[k]) ^ (72'd1 << pb[k]);
                do_read({c1, ref_enc(v0)});
                chk($sformatf("R5 pair %0d/%0d", pa[k], pb[k]), {rd_data, sbe, dbe},
                    {c1[63:0], v0, 2'b00, 2'b10});
            end
        end

        // R6: hold while strobe low and input changes
        @(negedge clk);
        rd_code = ~rd_code;
        @(negedge clk);
        chk("R6 hold", {rd_vld_o, rd_data, sbe, dbe}, {1'b0, c1[63:0], v0, 2'b00, 2'b10});

        // R7: injection
        do_write({v1, v0}, 1, 0);
        chk("R7 single inject", wr_code, {ref_enc(v1) ^ 72'd1, ref_enc(v0) ^ 72'd1});
        do_read(wr_code);
        chk("R7 single inject corrected", {rd_data, sbe, dbe}, {v1, v0, 2'b11, 2'b00});
        do_write({v1, v0}, 0, 1);
        chk("R7 double inject", wr_code, {ref_enc(v1) ^ 72'd3, ref_enc(v0) ^ 72'd3});
        do_read(wr_code);
        chk("R7 double inject flagged", {sbe, dbe}, 4'b0011);
        do_write({v1, v0}, 1, 1);
        chk("R7 both requests", wr_code, {ref_enc(v1) ^ 72'd3, ref_enc(v0) ^ 72'd3});

        // R8: encoder-only instance
        e_wr_data = VEC[7];
        do_write('0, 0, 0);
        chk("R8 enc-only store", e_wr_code, ref_enc(VEC[7]));
        e_rd_code = ref_enc(VEC[7]) ^ 72'h3;
        do_read('0);
        chk("R8 enc-only raw load", {e_rd_data, e_sbe, e_dbe}, {ref_enc(VEC[7]) ^ 72'h3, 2'b00});

        // R9: decoder-only instance, injection ignored
        d_wr_data = 72'hC3_1234_5678_9ABC_DEF0;
        do_write('0, 1, 0);
        chk("R9 dec-only pass single req", d_wr_code, 72'hC3_1234_5678_9ABC_DEF0);
        d_wr_data = 72'h5A_0F0F_0F0F_0F0F_0F0F;
        do_write('0, 0, 1);
        chk("R9 dec-only pass double req", d_wr_code, 72'h5A_0F0F_0F0F_0F0F_0F0F);
        d_rd_code = ref_enc(VEC[4]) ^ (72'd1 << 33);
        do_read('0);
        chk("R9 dec-only corrects", {d_rd_data, d_sbe, d_dbe}, {VEC[4], 2'b10});

        // R10: reset mid-run clears registers
        @(negedge clk);
        rst_n = 0;
        #1;
        chk("R10 reset mid-run", {wr_vld_o, wr_code, rd_vld_o, rd_data, sbe, dbe}, '0);
        @(negedge clk);
        rst_n = 1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule